// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a CPU's data-memory request port to an asynchronous SRAM-style bus outside the chip. The low address byte and the data byte share one 8-bit lane. The high address byte has its own output. An address-latch strobe (ALE) lets an external latch capture the low address byte before the lane is reused for data. Read and write strobes are active low. Every strobe is derived from the internal system clock, so the bus suits asynchronous memories only.

The address space is split into a lower and an upper sector at a programmable boundary. Each sector has its own 2-bit wait code, so a fast and a slow device can share the bus. A switchable keeper holds the last driven lane value whenever the controller stops driving. The shared lane appears as three plain signals: a value, an output enable and a keeper-active flag, plus a separate input for read data. The pad tri-state belongs to the chip's pad ring.

The CPU raises a request and holds it until `ready` is high for one cycle. For a read, `ready` comes with the returned byte.

Top module: `xbus_ctrl`

## Requirements
- R1: The 9-bit configuration word is laid out as follows: bits [2:0] boundary, [4:3] lower-sector wait code, [6:5] upper-sector wait code, bit 7 keeper enable, bit 8 interface enable. It is written with `cfg_we` and is readable on `cfg_rdata`. It resets to all zeros.
- R2: While the interface enable is 0:
  - `rd_n` and `wr_n` stay high, and ALE stays low;
  - the lane is released (`ad_oe` 0) and `ad_keep` is 0;
  - `ad_o` and `ahi_o` read 0;
  - `ready` never rises.
- R3: A request seen while the controller is idle starts phase T1 one cycle later. In T1, ALE is high, the lane drives the low address byte, `ahi_o` shows the high byte, and both strobes are high.
- R4: The strobe phase follows T1 and lasts 2 + E cycles. E is 0, 1, 2 and 2 for wait codes 00, 01, 10 and 11. For code 11 only, one hold cycle with both strobes high comes between the strobe phase and T4.
- R5: For a write, `wr_n` is low for the whole strobe phase and `rd_n` stays high. The lane drives the write byte from the first strobe cycle through T4.
- R6: For a read, `rd_n` is low for the whole strobe phase and the lane is released. The byte on `ad_i` at the clock edge that ends the last strobe cycle is presented on `rdata` in T4.
- R7: An access uses the upper-sector wait code when the boundary is nonzero and address bits [15:13] are greater than or equal to the boundary. Otherwise it uses the lower-sector code, which includes every access when the boundary is 0.
- R8: `ready` is high for exactly one cycle, in T4, with both strobes high. The controller is idle in the cycle after T4.
- R9: In T4, ALE is high only if `nxt_ram` was high when the request was accepted. ALE is low in every other phase except T1.
- R10: While the lane is released and the interface and keeper are both enabled:
  - `ad_keep` is 1;
  - `ad_o` holds the last value the controller drove.

  With the keeper disabled, `ad_keep` is 0 and `ad_o` reads 0.
- R11: `rd_n` and `wr_n` are never low together, and ALE is never high while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration word to write |
| cfg_rdata | output | 9 | Current configuration word |
| req | input | 1 | CPU access request, held until ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| nxt_ram | input | 1 | Next access also targets memory |
| ready | output | 1 | Access completes this cycle |
| rdata | output | 8 | Read byte, valid with ready |
| ad_i | input | 8 | Value seen on the shared lane |
| ad_o | output | 8 | Value driven or kept on the shared lane |
| ad_oe | output | 1 | Controller drives the shared lane |
| ad_keep | output | 1 | Keeper holds the shared lane |
| ahi_o | output | 8 | High address byte |
| ale_o | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A corrupted phase or cycle count shows at the ports within the same access: a strobe comes one cycle early or late, the hold cycle is missing, or `ready` arrives at the wrong index. The bench compares every port in every cycle of an access against a timeline computed from the wait code. A wrong sector decision changes the strobe length of that same access. A capture taken on the wrong edge returns a byte off by one, because the bench changes `ad_i` every cycle. A keeper register that fails to update shows in the first released cycle that follows a driven one.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int BND_W = 3;
    localparam int WS_W  = 2;

    typedef struct packed {
        logic             if_en;
        logic             keep_en;
        logic [WS_W-1:0]  ws_hi;
        logic [WS_W-1:0]  ws_lo;
        logic [BND_W-1:0] bnd;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_STB,
        PH_HOLD,
        PH_T4
    } phase_e;

    // extra strobe cycles beyond the base two
    function automatic logic [WS_W-1:0] ws_extra(input logic [WS_W-1:0] code);
        case (code)
            2'b00:   ws_extra = 2'd0;
            2'b01:   ws_extra = 2'd1;
            default: ws_extra = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);

    typedef struct packed {
        cfg_t c;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.c = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.c;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [BND_W-1:0] bnd,
    input  logic [WS_W-1:0]  ws_lo,
    input  logic [WS_W-1:0]  ws_hi,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             nxt_ram,
    input  logic [DW-1:0]    ad_i,
    output logic             ready,
    output logic [DW-1:0]    rdata,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             drive,
    output logic [DW-1:0]    dval,
    output logic [AW-DW-1:0] ahi
);

    localparam int HI_W = AW - DW;

    typedef struct packed {
        phase_e          ph;
        logic [WS_W-1:0] cnt;
        logic [WS_W-1:0] code;
        logic            we;
        logic            nxt;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdat;
        logic [DW-1:0]   rdat;
    } st_t;

    st_t  st_d, st_q;
    logic upper;

    assign upper = (bnd != '0) && (addr[AW-1 -: BND_W] >= bnd);

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (req) begin
                    st_d.ph   = PH_T1;
                    st_d.we   = we;
                    st_d.addr = addr;
                    st_d.wdat = wdata;
                    st_d.nxt  = nxt_ram;
                    st_d.code = upper ? ws_hi : ws_lo;
                end
            end
            PH_T1: begin
                st_d.ph  = PH_STB;
                st_d.cnt = 2'd1 + ws_extra(st_q.code);
            end
            PH_STB: begin
                if (st_q.cnt == '0) begin
                    if (!st_q.we) begin
                        st_d.rdat = ad_i;
                    end
                    st_d.ph = (st_q.code == 2'b11) ? PH_HOLD : PH_T4;
                end else begin
                    st_d.cnt = st_q.cnt - 2'd1;
                end
            end
            PH_HOLD: st_d.ph = PH_T4;
            PH_T4:   st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
        if (!en) begin
            st_d.ph = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    logic in_stb;
    assign in_stb = (st_q.ph == PH_STB);

    assign ready = (st_q.ph == PH_T4);
    assign rdata = st_q.rdat;
    assign ale   = (st_q.ph == PH_T1) || ((st_q.ph == PH_T4) && st_q.nxt);
    assign rd_n  = !(in_stb && !st_q.we);
    assign wr_n  = !(in_stb && st_q.we);
    assign drive = (st_q.ph == PH_T1) ||
                   (st_q.we && (in_stb || st_q.ph == PH_HOLD || st_q.ph == PH_T4));
    assign dval  = (st_q.ph == PH_T1) ? st_q.addr[DW-1:0] : st_q.wdat;
    assign ahi   = st_q.addr[AW-1 -: HI_W];

    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r11_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !drive);

    a_r2_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (rd_n && wr_n && !ready));

endmodule

// File: rtl/xbus_lane.sv
module xbus_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          keep_on,
    input  logic          drive,
    input  logic [DW-1:0] dval,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    output logic          ad_keep
);

    typedef struct packed {
        logic [DW-1:0] last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (drive) begin
            st_d.last = dval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ad_oe   = drive;
        ad_keep = keep_on && !drive;
        if (drive) begin
            ad_o = dval;
        end else if (keep_on) begin
            ad_o = st_q.last;
        end else begin
            ad_o = '0;
        end
    end

    a_r10_keep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_keep && $past(ad_keep)) |-> (ad_o == $past(ad_o)));

    a_r10_keep_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ad_oe) && ad_keep) |-> (ad_o == $past(ad_o)));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [8:0]       cfg_wdata,
    output logic [8:0]       cfg_rdata,
    input  logic             req,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             nxt_ram,
    output logic             ready,
    output logic [DW-1:0]    rdata,
    input  logic [DW-1:0]    ad_i,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe,
    output logic             ad_keep,
    output logic [AW-DW-1:0] ahi_o,
    output logic             ale_o,
    output logic             rd_n,
    output logic             wr_n
);

    cfg_t             cfg;
    logic             s_ready, s_ale, s_rd_n, s_wr_n, s_drive;
    logic [DW-1:0]    s_dval;
    logic [AW-DW-1:0] s_ahi;

    xbus_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    xbus_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg.if_en),
        .bnd     (cfg.bnd),
        .ws_lo   (cfg.ws_lo),
        .ws_hi   (cfg.ws_hi),
        .req     (req),
        .we      (req_we),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .nxt_ram (nxt_ram),
        .ad_i    (ad_i),
        .ready   (s_ready),
        .rdata   (rdata),
        .ale     (s_ale),
        .rd_n    (s_rd_n),
        .wr_n    (s_wr_n),
        .drive   (s_drive),
        .dval    (s_dval),
        .ahi     (s_ahi)
    );

    xbus_lane #(.DW(DW)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .keep_on (cfg.if_en && cfg.keep_en),
        .drive   (s_drive && cfg.if_en),
        .dval    (s_dval),
        .ad_o    (ad_o),
        .ad_oe   (ad_oe),
        .ad_keep (ad_keep)
    );

    assign cfg_rdata = cfg;
    assign ready     = s_ready && cfg.if_en;
    assign ale_o     = s_ale && cfg.if_en;
    assign rd_n      = s_rd_n || !cfg.if_en;
    assign wr_n      = s_wr_n || !cfg.if_en;
    assign ahi_o     = cfg.if_en ? s_ahi : '0;

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.if_en |-> (!ad_oe && !ad_keep && !ale_o && rd_n && wr_n));

endmodule

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic [8:0] cfg_rdata;
    logic       req = 1'b0, req_we = 1'b0, nxt_ram = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0, ad_i = '0;
    logic       ready, ad_oe, ad_keep, ale_o, rd_n, wr_n;
    logic [7:0] rdata, ad_o, ahi_o;

    int nchk = 0, nfail = 0;
    logic [7:0] last_drv = '0;
    logic [8:0] cur_cfg = '0;

    always #4 clk = ~clk;

    xbus_ctrl i_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .nxt_ram(nxt_ram), .ready(ready), .rdata(rdata),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .ad_keep(ad_keep),
        .ahi_o(ahi_o), .ale_o(ale_o), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
        end
    endtask

    function automatic int extra_of(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
    endfunction

    function automatic logic [1:0] code_of(input logic [8:0] c, input logic [15:0] a);
        if (c[2:0] != 3'd0 && a[15:13] >= c[2:0]) return c[6:5];
        return c[4:3];
    endfunction

    task automatic write_cfg(input logic [8:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_cfg = v;
        chk(cfg_rdata == v, "R1 cfg readback", cfg_rdata, v);
    endtask

    // expected lane value when released
    function automatic logic [7:0] rel_val();
        return cur_cfg[7] ? last_drv : 8'h00;
    endfunction

    task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                          input bit nx, input logic [7:0] base);
        logic [1:0] code;
        int s, hold, t4;
        bit t1, stb, hd, f4, e_oe;
        logic [7:0] e_o;
        code = code_of(cur_cfg, a);
        s = 2 + extra_of(code);
        hold = (code == 2'b11) ? 1 : 0;
        t4 = 2 + s + hold;
        @(negedge clk);
        // idle cycle before the request
        chk(!ad_oe && ad_o == rel_val(), "R10 idle lane", ad_o, rel_val());
        chk(ad_keep == cur_cfg[7], "R10 idle keep flag", ad_keep, cur_cfg[7]);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd; nxt_ram = nx;
        for (int i = 1; i <= 24; i++) begin
            @(negedge clk);
            if (i > t4) begin
                chk(0, "R8 ready missing", 0, 1);
                break;
            end
            t1  = (i == 1);
            stb = (i >= 2) && (i <= 1 + s);
            hd  = (hold == 1) && (i == 2 + s);
            f4  = (i == t4);
            e_oe = t1 || (we && (stb || hd || f4));
            e_o = t1 ? a[7:0] : (e_oe ? wd : rel_val());
            chk(ale_o == (t1 || (f4 && nx)), t1 ? "R3 ale in T1" : "R9 ale", ale_o, t1 || (f4 && nx));
            chk(rd_n == !(stb && !we), "R6 rd strobe", rd_n, !(stb && !we));
            chk(wr_n == !(stb && we), "R5 wr strobe", wr_n, !(stb && we));
            chk(ad_oe == e_oe, "R5 lane enable", ad_oe, e_oe);
            chk(ad_o == e_o, t1 ? "R3 low address" : "R10 lane value", ad_o, e_o);
            chk(ad_keep == (cur_cfg[7] && !e_oe), "R10 keep flag", ad_keep, cur_cfg[7] && !e_oe);
            chk(ready == f4, "R4 R8 ready timing", ready, f4);
            if (t1) chk(ahi_o == a[15:8], "R3 high address", ahi_o, a[15:8]);
            if (e_oe) last_drv = e_o;
            if (f4) begin
                if (!we) chk(rdata == 8'(base + 1 + s), "R6 read data", rdata, 8'(base + 1 + s));
                req = 1'b0;
                break;
            end
            ad_i = 8'(base + i);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [8:0] c;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 9'h0, "R1 reset config", cfg_rdata, 0);
        chk(rd_n && wr_n && !ale_o && !ad_oe && !ready, "R2 reset idle", {rd_n, wr_n, ale_o, ad_oe}, 4'hC);
        rst_n = 1'b1;

        // R2: disabled interface ignores requests
        @(negedge clk);
        req = 1'b1; req_addr = 16'hA55A; req_we = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!ready && rd_n && wr_n && !ale_o && !ad_oe && !ad_keep,
                "R2 disabled outputs", {ready, rd_n, wr_n, ale_o, ad_oe}, 5'b01100);
            chk(ahi_o == 8'h00 && ad_o == 8'h00, "R2 disabled lane", ad_o, 0);
        end
        req = 1'b0;

        // directed: every wait code in the lower sector, keeper on
        for (int k = 0; k < 4; k++) begin
            write_cfg({1'b1, 1'b1, 2'b00, 2'(k), 3'd0});
            access(1'b1, 16'hF012 + 16'(k), 8'hC0 + 8'(k), 1'b0, 8'h10);
            access(1'b0, 16'h0134, 8'h00, 1'b1, 8'h40 + 8'(k));
        end

        // R7: boundary edges, upper code 11 vs lower code 00
        write_cfg({1'b1, 1'b0, 2'b11, 2'b00, 3'd4});
        access(1'b0, 16'h7FFF, 8'h00, 1'b1, 8'h20);
        access(1'b0, 16'h8000, 8'h00, 1'b0, 8'h30);
        access(1'b1, 16'hE000, 8'h5A, 1'b1, 8'h00);

        // R10: keeper disabled, lane reads zero when released
        write_cfg({1'b1, 1'b0, 2'b01, 2'b10, 3'd1});
        access(1'b1, 16'h2233, 8'h99, 1'b0, 8'h00);
        access(1'b0, 16'h0011, 8'h00, 1'b0, 8'h70);

        // random mix
        for (int n = 0; n < 60; n++) begin
            if (n % 10 == 0) begin
                c = 9'($urandom);
                c[8] = 1'b1;
                write_cfg(c);
            end
            access(1'($urandom), 16'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
        end

        // R2: disabling again releases the lane and drops the keeper
        write_cfg(9'h080);
        @(negedge clk);
        chk(!ad_keep && ad_o == 8'h00 && ahi_o == 8'h00, "R2 disabled after use", ad_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule